// File: doc/BRIEF.md
# Terminal Receive Port

This block is the processor-facing side of a serial terminal's receive path. A deserializer upstream presents each finished character as an 8-bit byte together with a one-cycle strobe. The block keeps the most recent character in a buffer register. It also keeps a control/status register that holds a "character waiting" flag and an interrupt-enable flag, and it drives a level-sensitive interrupt request to the system interrupt logic.

Software reaches the block through a small word-addressed bus with read and write strobes. Address bit 1 chooses between the status register and the character buffer. Address bit 0 marks an access to the odd (upper) byte. Reading the buffer acknowledges the character: the waiting flag and the request both fall. A mode input selects 7-bit or 8-bit characters. The mask is applied when the character is latched, not when it is read.

Top module: `trx_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, that edge clears the character buffer, both status flags and `irq`. A read of either register afterwards returns 0.
- R2: `bus_addr[1]`=0 selects the status register and `bus_addr[1]`=1 selects the buffer. A status read returns the waiting flag in bit 7 and interrupt-enable in bit 6, with every other bit 0.
- R3: `bus_rdata` is loaded at the clock edge that samples `bus_rd`, so it is valid from the following cycle. It holds that value until the next read.
- R4: A buffer read returns the buffer zero-extended to 16 bits. The same edge clears the waiting flag and drops `irq`.
- R5: A status write with `bus_addr[0]`=1 (odd byte) changes nothing.
- R6: An even status write loads interrupt-enable from `bus_wdata[6]`. All other written bits, including bit 7, have no effect.
- R7: Writing interrupt-enable as 0 drops `irq`. Writing it as 1 while a character is waiting and the enable was clear raises `irq` at that edge.
- R8: A character strobe stores `char_data` masked to its low 7 bits when `mode_8bit`=0, or all 8 bits when `mode_8bit`=1. It sets the waiting flag and raises `irq` if interrupt-enable is set.
- R9: Writes to the buffer address leave the buffer, the flags and `irq` unchanged.
- R10: A new character overwrites a waiting one and no overrun flag is kept. When a character strobe and a buffer read fall on the same edge, the read returns the old character and the new character stays waiting.
- R11: `irq` is high exactly when the waiting flag and interrupt-enable are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Bit 1 selects the register, bit 0 marks an odd-byte access |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| char_valid | input | 1 | New character strobe from the deserializer |
| char_data | input | 8 | Incoming character |
| mode_8bit | input | 1 | 1 keeps 8 bits, 0 keeps 7 bits |
| irq | output | 1 | Level interrupt request |

## Verification
Every result is due one cycle after the edge that samples its stimulus. Read data, the flags and `irq` all come from registers loaded at that edge, so nothing settles in the same cycle. The bench changes inputs on the falling edge and samples on the next falling edge, half a cycle after the result has been registered. A check therefore sees the state left by exactly one stimulus. For collisions, both stimuli are driven in the same half cycle, so they land on one shared edge.

// File: rtl/trx_pkg.sv
// Package: shared sizes, bit positions and the decoded-action type for the
// terminal receive port. Assumes a 16-bit register word and 8-bit characters.
package trx_pkg;
    parameter int CSR_W    = 16;
    parameter int CHAR_W   = 8;
    parameter int DONE_POS = 7;
    parameter int IE_POS   = 6;
    parameter int ADDR_W   = 2;

    typedef struct packed {
        logic csr_rd;
        logic buf_rd;
        logic csr_wr;
    } trx_act_t;
endpackage

// File: rtl/trx_decode.sv
// Module: trx_decode
// Turns bus strobes and the address into the register actions that matter.
// Assumes bit 1 picks the register and bit 0 flags an odd-byte access.
// Buffer writes and odd-byte status writes produce no action at all.
module trx_decode
    import trx_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output trx_act_t          act
);
    localparam int SEL_BIT = 1;
    localparam int ODD_BIT = 0;

    // Purpose: one action flag per legal access.
    always_comb begin
        act.csr_rd = rd && !addr[SEL_BIT];
        act.buf_rd = rd &&  addr[SEL_BIT];
        act.csr_wr = wr && !addr[SEL_BIT] && !addr[ODD_BIT];
    end
endmodule

// File: rtl/trx_char_latch.sv
// Module: trx_char_latch
// Holds the most recent character, masked by mode at latch time.
// Assumes at least 2 bits per character; narrow mode drops the top bit.
module trx_char_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         wide,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] FULL_MASK   = {W{1'b1}};
    localparam logic [W-1:0] NARROW_MASK = {1'b0, {(W-1){1'b1}}};

    logic [W-1:0] mask;

    // Purpose: pick the bit mask for the current character mode.
    always_comb mask = wide ? FULL_MASK : NARROW_MASK;

    // Purpose: store a masked character on each strobe, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= din & mask;
    end
endmodule

// File: rtl/trx_status.sv
// Module: trx_status
// Keeps the waiting flag, interrupt-enable and the level interrupt request.
// Assumes at most one bus access per cycle. A character strobe outranks an
// acknowledge on the same edge, so a new character is never lost.
module trx_status
    import trx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  trx_act_t act,
    input  logic     ie_wdata,
    input  logic     char_valid,
    output logic     done_q,
    output logic     ie_q,
    output logic     irq_q
);
    logic done_nxt, ie_nxt, irq_nxt;

    // Purpose: next-state rules for the flags and the request, by event.
    always_comb begin
        done_nxt = done_q;
        ie_nxt   = ie_q;
        irq_nxt  = irq_q;
        if (act.csr_wr) begin
            ie_nxt = ie_wdata;
            if (!ie_wdata)           irq_nxt = 1'b0;
            else if (done_q && !ie_q) irq_nxt = 1'b1;
        end
        if (act.buf_rd) begin
            done_nxt = 1'b0;
            irq_nxt  = 1'b0;
        end
        if (char_valid) begin
            done_nxt = 1'b1;
            if (ie_nxt) irq_nxt = 1'b1;
        end
    end

    // Purpose: register the flags, all clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            ie_q   <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            done_q <= done_nxt;
            ie_q   <= ie_nxt;
            irq_q  <= irq_nxt;
        end
    end
endmodule

// File: rtl/trx_port.sv
// Module: trx_port (top)
// Memory-mapped receive port of a serial terminal: a character buffer plus a
// status register with waiting and interrupt-enable flags, and a level IRQ.
// Assumes single-cycle strobes and a deserializer that supplies whole bytes.
module trx_port
    import trx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [CSR_W-1:0]  bus_wdata,
    output logic [CSR_W-1:0]  bus_rdata,
    input  logic              char_valid,
    input  logic [CHAR_W-1:0] char_data,
    input  logic              mode_8bit,
    output logic              irq
);
    localparam int PAD_W = CSR_W - CHAR_W;

    trx_act_t          act;
    logic [CHAR_W-1:0] buf_q;
    logic              done_q;
    logic              ie_q;
    logic [CSR_W-1:0]  csr_view;
    logic [CSR_W-1:0]  unused_wdata;

    trx_decode u_decode (
        .addr (bus_addr),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .act  (act)
    );

    trx_char_latch #(.W(CHAR_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (char_valid),
        .din   (char_data),
        .wide  (mode_8bit),
        .q     (buf_q)
    );

    trx_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .act        (act),
        .ie_wdata   (bus_wdata[IE_POS]),
        .char_valid (char_valid),
        .done_q     (done_q),
        .ie_q       (ie_q),
        .irq_q      (irq)
    );

    // Purpose: only the interrupt-enable bit of write data is meaningful.
    always_comb unused_wdata = bus_wdata & ~(CSR_W'(1) << IE_POS);

    // Purpose: status word with implemented bits in place, the rest zero.
    always_comb begin
        csr_view           = '0;
        csr_view[DONE_POS] = done_q;
        csr_view[IE_POS]   = ie_q;
    end

    // Purpose: registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)           bus_rdata <= '0;
        else if (act.csr_rd)  bus_rdata <= csr_view;
        else if (act.buf_rd)  bus_rdata <= {{PAD_W{1'b0}}, buf_q};
    end
endmodule

// File: rtl/trx_port_checker.sv
// Module: trx_port_checker
// Property checks for trx_port, attached by bind. Observes ports and the
// registered flags and buffer.
module trx_port_checker
    import trx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              char_valid,
    input logic              mode_8bit,
    input logic [CHAR_W-1:0] buf_q,
    input logic              done_q,
    input logic              ie_q,
    input logic              irq
);
    // R11: request tracks waiting AND enable
    assert_irq_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (done_q && ie_q));

    // R4: acknowledge without a competing character clears the request
    assert_ack_drops_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[1] && !char_valid) |=> (!irq && !done_q));

    // R8: a character always leaves the waiting flag set
    assert_char_sets_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |=> done_q);

    // R8: narrow mode never stores the top bit
    assert_narrow_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && !mode_8bit) |=> !buf_q[CHAR_W-1]);

    // R5: odd-byte status write leaves the enable alone
    assert_odd_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'b01) |=> $stable(ie_q));

    // R9: buffer write without a character leaves buffer and flags alone
    assert_buf_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[1] && !bus_rd && !char_valid)
        |=> ($stable(buf_q) && $stable(done_q) && $stable(ie_q)));
endmodule

bind trx_port trx_port_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .char_valid (char_valid),
    .mode_8bit  (mode_8bit),
    .buf_q      (buf_q),
    .done_q     (done_q),
    .ie_q       (ie_q),
    .irq        (irq)
);

// File: tb/trx_port_bench.sv
// Directed bench for trx_port: one task per scenario, each checking itself.
module trx_port_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  bus_addr;
    logic        bus_rd, bus_wr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        char_valid;
    logic [7:0]  char_data;
    logic        mode_8bit;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [15:0] rv;

    localparam logic [1:0] A_CSR = 2'b00;
    localparam logic [1:0] A_ODD = 2'b01;
    localparam logic [1:0] A_BUF = 2'b10;

    always #5 clk = ~clk;

    trx_port u_trx_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .char_valid(char_valid), .char_data(char_data),
        .mode_8bit(mode_8bit), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        bus_rd = 0; bus_wr = 0; char_valid = 0;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk); idle();
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1;
        @(negedge clk); idle(); d = bus_rdata;
    endtask

    task automatic send_char(input logic [7:0] c);
        @(negedge clk); char_data = c; char_valid = 1;
        @(negedge clk); idle();
    endtask

    task automatic t_reset();
        bus_read(A_CSR, rv); check("R1 csr", rv, 16'h0000);
        bus_read(A_BUF, rv); check("R1 buf", rv, 16'h0000);
        check("R1 irq", {15'd0, irq}, 16'd0);
    endtask

    task automatic t_wide_char();
        mode_8bit = 1;
        send_char(8'hC5);
        check("R11 irq off without enable", {15'd0, irq}, 16'd0);
        bus_read(A_CSR, rv); check("R2 csr done", rv, 16'h0080);
        bus_read(A_BUF, rv); check("R8 wide char", rv, 16'h00C5);
        bus_read(A_CSR, rv); check("R4 done cleared", rv, 16'h0000);
    endtask

    task automatic t_narrow_char();
        mode_8bit = 0;
        send_char(8'hC5);
        bus_read(A_BUF, rv); check("R8 narrow char", rv, 16'h0045);
        mode_8bit = 1;
    endtask

    task automatic t_late_enable();
        send_char(8'h5A);
        bus_write(A_CSR, 16'h0040);
        check("R7 late enable raises", {15'd0, irq}, 16'd1);
        bus_read(A_CSR, rv); check("R2 csr both", rv, 16'h00C0);
        bus_write(A_CSR, 16'h0000);
        check("R7 disable drops", {15'd0, irq}, 16'd0);
        bus_write(A_CSR, 16'h0040);
        check("R7 re-enable raises", {15'd0, irq}, 16'd1);
        bus_read(A_BUF, rv); check("R4 data", rv, 16'h005A);
        check("R4 irq dropped", {15'd0, irq}, 16'd0);
    endtask

    task automatic t_enabled_arrival();
        send_char(8'h31);
        check("R8 irq on arrival", {15'd0, irq}, 16'd1);
        bus_read(A_BUF, rv); check("R11 irq after ack", {15'd0, irq}, 16'd0);
        bus_write(A_CSR, 16'h0000);
    endtask

    task automatic t_odd_and_bits();
        bus_write(A_ODD, 16'hFFFF);
        bus_read(A_CSR, rv); check("R5 odd write ignored", rv, 16'h0000);
        bus_write(A_CSR, 16'hFFBF);
        bus_read(A_CSR, rv); check("R6 other bits ignored", rv, 16'h0000);
        bus_write(A_CSR, 16'hFFFF);
        bus_read(A_CSR, rv); check("R6 only enable set", rv, 16'h0040);
        check("R11 no irq without done", {15'd0, irq}, 16'd0);
        bus_write(A_CSR, 16'h0000);
    endtask

    task automatic t_buf_write();
        send_char(8'h77);
        bus_write(A_BUF, 16'h00AA);
        bus_read(A_CSR, rv); check("R9 flags unchanged", rv, 16'h0080);
        bus_read(A_BUF, rv); check("R9 buffer unchanged", rv, 16'h0077);
    endtask

    task automatic t_rdata_hold();
        repeat (3) @(negedge clk);
        check("R3 rdata held", bus_rdata, 16'h0077);
    endtask

    task automatic t_overrun();
        send_char(8'h11);
        send_char(8'h22);
        bus_read(A_CSR, rv); check("R10 no overrun flag", rv, 16'h0080);
        bus_read(A_BUF, rv); check("R10 overwrite", rv, 16'h0022);
    endtask

    task automatic t_collide();
        bus_write(A_CSR, 16'h0040);
        send_char(8'h33);
        @(negedge clk);
        bus_addr = A_BUF; bus_rd = 1; char_data = 8'h44; char_valid = 1;
        @(negedge clk); idle();
        check("R10 collide old data", bus_rdata, 16'h0033);
        check("R10 collide irq kept", {15'd0, irq}, 16'd1);
        bus_read(A_BUF, rv); check("R10 collide new data", rv, 16'h0044);
    endtask

    initial begin
        rst_n = 0; bus_addr = 0; bus_wdata = 0; char_data = 0; mode_8bit = 1;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_wide_char();
        t_narrow_char();
        t_late_enable();
        t_enabled_arrival();
        t_odd_and_bits();
        t_buf_write();
        t_rdata_hold();
        t_overrun();
        t_collide();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule